// File: doc/BRIEF.md
# Full-Map Coherence Directory

This block keeps the coherence directory for one memory bank shared by a fixed number of processors. For every block of the bank it records a presence bit for each processor and a single dirty bit. It takes read and write (ownership) requests, sends invalidation and recall messages to caches, collects their replies, writes recalled data back to the bank and grants the line to the requester.

The network between caches and directory is taken to be reliable and in order between any two endpoints. Messages are multicast: the destination field is a mask with bit i standing for processor i. The block serves one transaction at a time. A request is only taken while `req_ready` is high. Directory state lives in a synchronous RAM that is swept to zero after reset. Bank data sits behind a simple memory port with one cycle of read latency.

Top module: `dir_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low while the directory RAM is cleared, one entry per cycle (NBLK cycles). It then rises, and every block starts clean with no sharers.
- R2: A read of a clean block sends no message. It reads the bank, and the grant (`grant_excl`=0, bank data) appears 3 cycles after the accepting edge. The requester is recorded as a sharer.
- R3: A read of a dirty block sends exactly one message one cycle after acceptance. The message has kind 2 (recall to shared), and its destination mask holds only the owner.
- R4: When the owner replies to a recall, the grant carrying the reply data appears on the next edge, and the same data is written to the bank in that cycle. A reply from any other processor is ignored. After a recall for a read, the dirty bit is clear, so the next read gets the recalled data from the bank with no message.
- R5: A write to a clean block with other sharers sends kind 1 (invalidate) one cycle after acceptance. Its destination mask is every sharer except the requester. With no other sharer, no message is sent, and the grant follows 3 cycles after acceptance.
- R6: After an invalidate, the grant waits for an acknowledgement from every invalidated processor. Replies from processors not in the mask are ignored. The exclusive grant (`grant_excl`=1, bank data) appears 2 cycles after the last acknowledgement.
- R7: After a write grant, the block is dirty and the requester is its only holder, so a later read recalls from that processor.
- R8: A write to a dirty block sends kind 3 (recall and invalidate) to the owner only. On the owner's reply, the bank is updated and an exclusive grant with the reply data is issued; the requester becomes the new owner.
- R9: From the accepting edge until the grant, `req_ready` is low and no further request is taken.
- R10: `msg_valid` and `grant_valid` are single-cycle pulses, and a grant never coincides with a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle, request taken on this edge |
| req_write | input | 1 | 1 = write (ownership), 0 = read |
| req_src | input | PW | Requesting processor index |
| req_addr | input | AW | Block index |
| msg_valid | output | 1 | Message pulse to caches |
| msg_kind | output | 2 | 1 invalidate, 2 recall to shared, 3 recall and invalidate |
| msg_dst | output | NPROC | Destination mask, bit i = processor i |
| msg_addr | output | AW | Block the message concerns |
| rsp_valid | input | 1 | Reply from a cache |
| rsp_src | input | PW | Replying processor |
| rsp_data | input | DW | Line data carried by a recall reply |
| mem_en | output | 1 | Bank access enable |
| mem_we | output | 1 | Bank write enable |
| mem_addr | output | AW | Bank address |
| mem_wdata | output | DW | Bank write data |
| mem_rdata | input | DW | Bank read data, valid the cycle after the enable cycle |
| grant_valid | output | 1 | Grant pulse |
| grant_dst | output | PW | Processor granted |
| grant_excl | output | 1 | 1 = exclusive (dirty) grant |
| grant_data | output | DW | Line data |
| grant_addr | output | AW | Block granted |

## Verification
All results are counted in edges from the edge that takes a request. A message is due one edge later. A clean read or a write with no other sharer grants on the third edge. A grant after a recall comes on the edge that samples the owner's reply, and a grant after invalidation comes two edges after the last acknowledgement. The bench drives inputs on falling edges and samples on the falling edge after each rising edge. At every intermediate sample it checks that no grant and no stray message has appeared, so an early or late result fails as surely as a wrong one. Memory write-back and dirty-bit clearing are checked through later reads of the same block.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [2:0] {
    ST_INIT, ST_IDLE, ST_LOOK, ST_MRD1, ST_MRD2, ST_WAIT_ACK, ST_WAIT_RCL
  } dir_st_t;

  localparam logic [1:0] MSG_INV     = 2'd1;
  localparam logic [1:0] MSG_RCL_SHR = 2'd2;
  localparam logic [1:0] MSG_RCL_INV = 2'd3;
endpackage

// File: rtl/dir_state_ram.sv
// Directory entry storage: one write port, one synchronous read port.
module dir_state_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 5,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dir_owner_find.sv
// Turns the presence mask of a dirty block into the owner index.
module dir_owner_find #(
  parameter int N  = 4,
  localparam int PW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [PW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (mask[i]) idx = PW'(i);
  end
endmodule

// File: rtl/dir_ack_tracker.sv
// Holds the processors still owing an invalidation acknowledgement.
module dir_ack_tracker #(
  parameter int N  = 4,
  localparam int PW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [N-1:0]  load_mask,
  input  logic          ack_valid,
  input  logic [PW-1:0] ack_src,
  output logic          last_ack
);
  logic [N-1:0] pending, hit_mask, remaining;
  logic         hit;

  always_comb begin
    hit       = ack_valid && pending[ack_src];
    hit_mask  = hit ? (N'(1) << ack_src) : '0;
    remaining = pending & ~hit_mask;
    last_ack  = hit && (remaining == '0);
  end

  always_ff @(posedge clk) begin
    if (rst)       pending <= '0;
    else if (load) pending <= load_mask;
    else           pending <= remaining;
  end
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
  import dir_pkg::*;
#(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  parameter int DW    = 32,
  localparam int PW   = $clog2(NPROC),
  localparam int AW   = $clog2(NBLK),
  localparam int EW   = NPROC + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [PW-1:0]    req_src,
  input  logic [AW-1:0]    req_addr,
  output logic             msg_valid,
  output logic [1:0]       msg_kind,
  output logic [NPROC-1:0] msg_dst,
  output logic [AW-1:0]    msg_addr,
  input  logic             rsp_valid,
  input  logic [PW-1:0]    rsp_src,
  input  logic [DW-1:0]    rsp_data,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic             grant_valid,
  output logic [PW-1:0]    grant_dst,
  output logic             grant_excl,
  output logic [DW-1:0]    grant_data,
  output logic [AW-1:0]    grant_addr
);
  dir_st_t          st;
  logic [AW-1:0]    init_cnt;
  logic [PW-1:0]    cur_src, owner_q;
  logic [AW-1:0]    cur_addr;
  logic             cur_write;
  logic [NPROC-1:0] pres_q;

  logic [EW-1:0]    ent_rd, dw_data;
  logic             dw_en;
  logic [AW-1:0]    dw_addr;
  logic [NPROC-1:0] ent_pres, src_bit, others;
  logic             ent_dirty;
  logic [PW-1:0]    owner_idx;
  logic             trk_load, last_ack, rcl_hit;
  logic [EW-1:0]    new_entry;

  assign req_ready = (st == ST_IDLE);
  assign ent_pres  = ent_rd[NPROC-1:0];
  assign ent_dirty = ent_rd[NPROC];
  assign src_bit   = NPROC'(1) << cur_src;
  assign others    = ent_pres & ~src_bit;
  assign rcl_hit   = (st == ST_WAIT_RCL) && rsp_valid && (rsp_src == owner_q);
  assign new_entry = cur_write ? {1'b1, src_bit} : {1'b0, pres_q | src_bit};
  assign trk_load  = (st == ST_LOOK) && !ent_dirty && cur_write && (others != '0);

  always_comb begin
    dw_en   = 1'b0;
    dw_addr = cur_addr;
    dw_data = new_entry;
    if (st == ST_INIT) begin
      dw_en   = 1'b1;
      dw_addr = init_cnt;
      dw_data = '0;
    end else if (st == ST_MRD2 || rcl_hit) begin
      dw_en = 1'b1;
    end
  end

  dir_state_ram #(.DEPTH(NBLK), .W(EW)) u_ram (
    .clk(clk), .we(dw_en), .waddr(dw_addr), .wdata(dw_data),
    .raddr(req_addr), .rdata(ent_rd)
  );

  dir_owner_find #(.N(NPROC)) u_own (.mask(ent_pres), .idx(owner_idx));

  dir_ack_tracker #(.N(NPROC)) u_trk (
    .clk(clk), .rst(rst), .load(trk_load), .load_mask(others),
    .ack_valid(rsp_valid && st == ST_WAIT_ACK), .ack_src(rsp_src),
    .last_ack(last_ack)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_INIT;
      init_cnt    <= '0;
      cur_src     <= '0;
      cur_addr    <= '0;
      cur_write   <= 1'b0;
      owner_q     <= '0;
      pres_q      <= '0;
      msg_valid   <= 1'b0;
      msg_kind    <= '0;
      msg_dst     <= '0;
      msg_addr    <= '0;
      mem_en      <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      grant_valid <= 1'b0;
      grant_dst   <= '0;
      grant_excl  <= 1'b0;
      grant_data  <= '0;
      grant_addr  <= '0;
    end else begin
      msg_valid   <= 1'b0;
      grant_valid <= 1'b0;
      mem_en      <= 1'b0;
      mem_we      <= 1'b0;
      case (st)
        ST_INIT: begin
          init_cnt <= init_cnt + 1'b1;
          if (init_cnt == AW'(NBLK - 1)) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            cur_src   <= req_src;
            cur_addr  <= req_addr;
            cur_write <= req_write;
            st        <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          pres_q  <= ent_pres;
          owner_q <= owner_idx;
          if (ent_dirty) begin
            msg_valid <= 1'b1;
            msg_kind  <= cur_write ? MSG_RCL_INV : MSG_RCL_SHR;
            msg_dst   <= ent_pres;
            msg_addr  <= cur_addr;
            st        <= ST_WAIT_RCL;
          end else if (trk_load) begin
            msg_valid <= 1'b1;
            msg_kind  <= MSG_INV;
            msg_dst   <= others;
            msg_addr  <= cur_addr;
            st        <= ST_WAIT_ACK;
          end else begin
            mem_en   <= 1'b1;
            mem_addr <= cur_addr;
            st       <= ST_MRD1;
          end
        end
        ST_WAIT_ACK: begin
          if (last_ack) begin
            mem_en   <= 1'b1;
            mem_addr <= cur_addr;
            st       <= ST_MRD1;
          end
        end
        ST_MRD1: st <= ST_MRD2;
        ST_MRD2: begin
          grant_valid <= 1'b1;
          grant_dst   <= cur_src;
          grant_excl  <= cur_write;
          grant_data  <= mem_rdata;
          grant_addr  <= cur_addr;
          st          <= ST_IDLE;
        end
        ST_WAIT_RCL: begin
          if (rcl_hit) begin
            mem_en      <= 1'b1;
            mem_we      <= 1'b1;
            mem_addr    <= cur_addr;
            mem_wdata   <= rsp_data;
            grant_valid <= 1'b1;
            grant_dst   <= cur_src;
            grant_excl  <= cur_write;
            grant_data  <= rsp_data;
            grant_addr  <= cur_addr;
            st          <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dir_ctrl_chk.sv
module dir_ctrl_chk #(
  parameter int NPROC = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             msg_valid,
  input logic [1:0]       msg_kind,
  input logic [NPROC-1:0] msg_dst,
  input logic             mem_en,
  input logic             mem_we,
  input logic             grant_valid
);
  p_grant_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    grant_valid |=> !grant_valid);
  p_msg_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> !msg_valid);
  p_msg_no_grant_r10: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> !grant_valid);
  p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  p_recall_single_r3: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind != 2'd1) |-> ($countones(msg_dst) == 1));
  p_inv_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_kind == 2'd1) |-> (msg_dst != '0));
  p_wb_with_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> grant_valid);
endmodule

bind dir_ctrl dir_ctrl_chk #(.NPROC(NPROC)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_dst(msg_dst),
  .mem_en(mem_en), .mem_we(mem_we), .grant_valid(grant_valid)
);

// File: tb/sim_dir_ctrl.sv
`timescale 1ns/1ps
module sim_dir_ctrl;
  localparam int NPROC = 4;
  localparam int NBLK  = 16;
  localparam int DW    = 32;
  localparam int PW    = $clog2(NPROC);
  localparam int AW    = $clog2(NBLK);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [PW-1:0] req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic msg_valid; logic [1:0] msg_kind; logic [NPROC-1:0] msg_dst; logic [AW-1:0] msg_addr;
  logic rsp_valid = 1'b0; logic [PW-1:0] rsp_src = '0; logic [DW-1:0] rsp_data = '0;
  logic mem_en, mem_we; logic [AW-1:0] mem_addr; logic [DW-1:0] mem_wdata, mem_rdata;
  logic grant_valid, grant_excl; logic [PW-1:0] grant_dst;
  logic [DW-1:0] grant_data; logic [AW-1:0] grant_addr;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  dir_ctrl #(.NPROC(NPROC), .NBLK(NBLK), .DW(DW)) u0 (.*);

  logic [DW-1:0] bank [NBLK];
  initial for (int a = 0; a < NBLK; a++) bank[a] = 32'hA000_0000 + a;
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bank[mem_addr] <= mem_wdata;
      else        mem_rdata <= bank[mem_addr];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input int src, input int addr, input bit wr, input string tag);
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " ready before request"}, 64'(req_ready), 1);
    req_valid = 1'b1; req_src = PW'(src); req_addr = AW'(addr); req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_msg(input logic [1:0] kind, input logic [NPROC-1:0] dst, input string tag);
    @(negedge clk);
    chk(msg_valid == 1'b1, {tag, " msg valid"}, 64'(msg_valid), 1);
    chk(msg_kind == kind, {tag, " msg kind"}, 64'(msg_kind), 64'(kind));
    chk(msg_dst == dst, {tag, " msg dst"}, 64'(msg_dst), 64'(dst));
  endtask

  // n falling-edge samples; grant only on the last, never a message
  task automatic wait_grant(input int n, input int dst, input logic [DW-1:0] data,
                            input bit excl, input string tag);
    for (int i = 1; i <= n; i++) begin
      if (i > 1 || n > 0) @(negedge clk);
      chk(msg_valid == 1'b0, {tag, " no message"}, 64'(msg_valid), 0);
      if (i < n) begin
        chk(grant_valid == 1'b0, {tag, " no early grant"}, 64'(grant_valid), 0);
        chk(req_ready == 1'b0, {tag, " busy R9"}, 64'(req_ready), 0);
      end
    end
    chk(grant_valid == 1'b1, {tag, " grant valid"}, 64'(grant_valid), 1);
    chk(grant_dst == PW'(dst), {tag, " grant dst"}, 64'(grant_dst), 64'(dst));
    chk(grant_data == data, {tag, " grant data"}, 64'(grant_data), 64'(data));
    chk(grant_excl == excl, {tag, " grant excl"}, 64'(grant_excl), 64'(excl));
  endtask

  task automatic send_rsp(input int src, input logic [DW-1:0] data);
    rsp_valid = 1'b1; rsp_src = PW'(src); rsp_data = data;
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic recall_grant(input int src, input logic [DW-1:0] data, input int dst,
                              input bit excl, input string tag);
    send_rsp(src, data);
    chk(grant_valid == 1'b1, {tag, " grant on reply edge"}, 64'(grant_valid), 1);
    chk(grant_dst == PW'(dst), {tag, " grant dst"}, 64'(grant_dst), 64'(dst));
    chk(grant_data == data, {tag, " grant data"}, 64'(grant_data), 64'(data));
    chk(grant_excl == excl, {tag, " grant excl"}, 64'(grant_excl), 64'(excl));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready == 1'b0, "R1 ready low during sweep", 64'(req_ready), 0);
    repeat (NBLK + 1) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after sweep", 64'(req_ready), 1);
  endtask

  task automatic t_clean_reads;
    issue(0, 3, 0, "R2 read p0");
    wait_grant(3, 0, 32'hA000_0003, 0, "R2 read p0");
    issue(2, 3, 0, "R2 read p2");
    wait_grant(3, 2, 32'hA000_0003, 0, "R2 read p2");
  endtask

  task automatic t_write_shared;
    issue(1, 3, 1, "R5 write p1");
    expect_msg(2'd1, 4'b0101, "R5 inv sharers");
    send_rsp(3, '0); // not invalidated: ignored
    chk(grant_valid == 1'b0, "R6 stray ack ignored", 64'(grant_valid), 0);
    send_rsp(0, '0);
    chk(grant_valid == 1'b0, "R6 waits for all acks", 64'(grant_valid), 0);
    @(negedge clk);
    chk(grant_valid == 1'b0, "R6 still waiting", 64'(grant_valid), 0);
    chk(req_ready == 1'b0, "R9 busy while waiting", 64'(req_ready), 0);
    send_rsp(2, '0);
    wait_grant(2, 1, 32'hA000_0003, 1, "R6 last ack");
  endtask

  task automatic t_dirty_read;
    issue(3, 3, 0, "R3 read dirty");
    expect_msg(2'd2, 4'b0010, "R7 R3 recall owner p1");
    send_rsp(2, 32'h1111_1111); // wrong source
    chk(grant_valid == 1'b0, "R4 non-owner reply ignored", 64'(grant_valid), 0);
    recall_grant(1, 32'hDEAD_0003, 3, 0, "R4 recall");
    issue(0, 3, 0, "R4 reread");
    wait_grant(3, 0, 32'hDEAD_0003, 0, "R4 bank updated, clean");
  endtask

  task automatic t_write_dirty;
    issue(2, 3, 1, "R5 write p2");
    expect_msg(2'd1, 4'b1011, "R5 inv excludes requester");
    send_rsp(0, '0); send_rsp(3, '0); send_rsp(1, '0);
    wait_grant(2, 2, 32'hDEAD_0003, 1, "R6 grant p2");
    issue(0, 3, 1, "R8 write dirty");
    expect_msg(2'd3, 4'b0100, "R8 recall-inv owner p2");
    recall_grant(2, 32'hBEEF_0003, 0, 1, "R8 grant p0");
    issue(1, 3, 0, "R8 new owner");
    expect_msg(2'd2, 4'b0001, "R8 owner now p0");
    recall_grant(0, 32'hCAFE_0003, 1, 0, "R8 recall p0");
  endtask

  task automatic t_write_private;
    issue(1, 5, 1, "R5 write unshared");
    wait_grant(3, 1, 32'hA000_0005, 1, "R5 no sharers");
    issue(2, 5, 0, "R7 read after write");
    expect_msg(2'd2, 4'b0010, "R7 recall writer");
    recall_grant(1, 32'h5555_0005, 2, 0, "R7 recall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_clean_reads;
    t_write_shared;
    t_dirty_read;
    t_write_dirty;
    t_write_private;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule